// File: doc/BRIEF.md
# Overcurrent Fault Latch Controller

This block holds the fault state of one half-bridge phase. A digital overcurrent flag from an external comparator is accepted only while the filtered low-side command is high. When it is accepted, a local latch sets. The latch then asks the interlock logic to turn off both gate outputs, and it pulls a shared open-drain fault line low.

Several phases and the controller share that fault line. When any of them pulls it low, this phase also shuts down, but it does not record the event in its own latch. The latch clears only through a deglitched fault-reset input. The sensed line level passes through its own low-level filter, so short dips on the line are rejected.

The block has no analog parts. The fault line appears as a sensed input plus a drive-low enable. Both filter lengths are parameters counted in clock cycles.

Top module: `ocfault_top`

## Requirements
- R1: When `ocFlag` and `lowCmd` are both high at a clock edge, `lineDriveLow` and `shutdownReq` are high from the next cycle.
- R2: An overcurrent flag while `lowCmd` is low has no effect: `lineDriveLow` and `shutdownReq` stay low.
- R3: Once set, the latch stays set after the overcurrent flag and the low-side command fall, until a qualified reset clears it.
- R4: A `resetReq` high pulse lasting fewer than RST_FILT clock cycles is ignored, and the latch stays set.
- R5: A `resetReq` held high for RST_FILT or more cycles clears the latch. `lineDriveLow` and `shutdownReq` fall RST_FILT+1 cycles after `resetReq` first goes high.
- R6: A trip takes priority over a reset. While the overcurrent flag and `lowCmd` stay high, a held reset leaves the latch set.
- R7: When `lineSense` is low for LINE_FILT or more consecutive cycles, `shutdownReq` goes high. `lineDriveLow` stays low, because an external pull-low never sets the local latch.
- R8: A `lineSense` low pulse shorter than LINE_FILT cycles does not raise `shutdownReq`.
- R9: When `lineSense` returns high and no local fault is latched, `shutdownReq` falls one cycle later.
- R10: After reset (`rstN` low), `shutdownReq` and `lineDriveLow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ocFlag | input | 1 | Overcurrent comparator flag, high = over threshold |
| lowCmd | input | 1 | Filtered low-side command |
| resetReq | input | 1 | Fault-reset request, active high, unfiltered |
| lineSense | input | 1 | Sensed level of the shared fault line, low = fault |
| shutdownReq | output | 1 | Request to the interlock to turn off both outputs |
| lineDriveLow | output | 1 | Open-drain pull-down enable for the fault line |

## Verification
The hardest situation to reach is a reset request that lands exactly on the filter boundary, or that overlaps a trip that is still active. A latch that clears one cycle early or late looks like a working design unless the pulse width sits right at RST_FILT.

The bench first sets the latch with a single trip cycle. It then sweeps the reset pulse width from one cycle up past the filter length, and it sweeps the width of the external line pulse the same way. Separately, it holds the reset high through a continuing trip and checks that the latch clears only once the trip is removed.

// File: rtl/ocfault_pkg.sv
package ocfault_pkg;
  // Strobes from the control decision logic to the latch datapath
  typedef struct packed {
    logic setLatch;
    logic clrLatch;
  } latchStrobe_t;

  // Qualified status returned from the datapath filters
  typedef struct packed {
    logic rstQual;
    logic lineLow;
    logic latchQ;
  } latchStatus_t;
endpackage

// File: rtl/ocfault_filter.sv
// Consecutive-cycle qualifier: the output goes true once the watched level
// has been seen for LEN edges in a row, and drops on the first edge it is absent.
module ocfault_filter #(
  parameter int unsigned LEN        = 4,
  parameter bit          ACTIVE_LOW = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic qualOut
);
  localparam int unsigned CntW = $clog2(LEN + 1);

  logic [CntW-1:0] cnt;
  logic            seen;

  generate
    if (ACTIVE_LOW) begin : g_low
      assign seen = ~rawIn;
    end else begin : g_high
      assign seen = rawIn;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (!seen) begin
      cnt <= '0;
    end else if (cnt != CntW'(LEN)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign qualOut = (cnt == CntW'(LEN));
endmodule

// File: rtl/ocfault_control.sv
module ocfault_control
  import ocfault_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         ocFlag,
  input  logic         lowCmd,
  input  latchStatus_t status,
  output latchStrobe_t strb
);
  logic tripNow;

  // Overcurrent only counts while the low-side switch is commanded on
  assign tripNow       = ocFlag & lowCmd;
  assign strb.setLatch = tripNow;
  // Trip wins: a reset request is not applied while a trip is active
  assign strb.clrLatch = status.rstQual & ~tripNow & status.latchQ;

  // R2
  oc_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ocFlag && !lowCmd) |-> !strb.setLatch);

  // R6
  trip_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.setLatch |-> !strb.clrLatch);
endmodule

// File: rtl/ocfault_datapath.sv
module ocfault_datapath
  import ocfault_pkg::*;
#(
  parameter int unsigned RST_FILT  = 4,
  parameter int unsigned LINE_FILT = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         resetReq,
  input  logic         lineSense,
  input  latchStrobe_t strb,
  output latchStatus_t status,
  output logic         shutdownReq,
  output logic         lineDriveLow
);
  logic latchQ;
  logic rstQual;
  logic lineLow;

  ocfault_filter #(.LEN(RST_FILT), .ACTIVE_LOW(1'b0)) u_rstFilt (
    .clk(clk), .rstN(rstN), .rawIn(resetReq), .qualOut(rstQual));

  ocfault_filter #(.LEN(LINE_FILT), .ACTIVE_LOW(1'b1)) u_lineFilt (
    .clk(clk), .rstN(rstN), .rawIn(lineSense), .qualOut(lineLow));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ <= 1'b0;
    end else if (strb.setLatch) begin
      latchQ <= 1'b1;
    end else if (strb.clrLatch) begin
      latchQ <= 1'b0;
    end
  end

  assign status.rstQual = rstQual;
  assign status.lineLow = lineLow;
  assign status.latchQ  = latchQ;
  assign lineDriveLow   = latchQ;
  assign shutdownReq    = latchQ | lineLow;

  // R1
  trip_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.setLatch |=> latchQ);

  // R5
  rst_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrLatch && !strb.setLatch) |=> !latchQ);

  // R7
  ext_no_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!latchQ && !strb.setLatch) |=> !latchQ);

  // R4
  rst_qual_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstQual) |-> $past(resetReq));
endmodule

// File: rtl/ocfault_top.sv
module ocfault_top
  import ocfault_pkg::*;
#(
  parameter int unsigned RST_FILT  = 4,
  parameter int unsigned LINE_FILT = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic ocFlag,
  input  logic lowCmd,
  input  logic resetReq,
  input  logic lineSense,
  output logic shutdownReq,
  output logic lineDriveLow
);
  latchStrobe_t strb;
  latchStatus_t status;

  ocfault_control u_ctrl (
    .clk(clk), .rstN(rstN), .ocFlag(ocFlag), .lowCmd(lowCmd),
    .status(status), .strb(strb));

  ocfault_datapath #(.RST_FILT(RST_FILT), .LINE_FILT(LINE_FILT)) u_dp (
    .clk(clk), .rstN(rstN), .resetReq(resetReq), .lineSense(lineSense),
    .strb(strb), .status(status), .shutdownReq(shutdownReq),
    .lineDriveLow(lineDriveLow));
endmodule

// File: tb/ocfault_top_tb.sv
module ocfault_top_tb;
  localparam int unsigned RF = 4;
  localparam int unsigned LF = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ocFlag = 1'b0, lowCmd = 1'b0, resetReq = 1'b0, lineSense = 1'b1;
  logic shutdownReq, lineDriveLow;
  int nChk = 0, nBad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ocfault_top #(.RST_FILT(RF), .LINE_FILT(LF)) u_dut (
    .clk(clk), .rstN(rstN), .ocFlag(ocFlag), .lowCmd(lowCmd),
    .resetReq(resetReq), .lineSense(lineSense),
    .shutdownReq(shutdownReq), .lineDriveLow(lineDriveLow));

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(string req, logic act, logic exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic setLatch();
    ocFlag = 1; lowCmd = 1; tick(); ocFlag = 0; lowCmd = 0;
  endtask

  task automatic clearLatch();
    resetReq = 1; tick(RF + 1); resetReq = 0; tick(2);
  endtask

  initial begin
    tick(2);
    // R10 reset state
    chk("R10 shutdown", shutdownReq, 1'b0);
    chk("R10 drive", lineDriveLow, 1'b0);
    rstN = 1; tick();

    // R1/R2 sweep all oc/lowCmd combinations
    for (int c = 0; c < 4; c++) begin
      ocFlag = c[0]; lowCmd = c[1];
      tick();
      chk(c == 3 ? "R1 drive" : "R2 drive", lineDriveLow, c == 3);
      chk(c == 3 ? "R1 shutdown" : "R2 shutdown", shutdownReq, c == 3);
      ocFlag = 0; lowCmd = 0;
      // R3 holds after trip removed
      tick(3);
      chk("R3 hold", lineDriveLow, c == 3);
      if (c == 3) clearLatch();
    end

    // R4/R5 reset pulse width sweep
    for (int w = 1; w <= RF + 2; w++) begin
      setLatch();
      resetReq = 1;
      tick(w);
      resetReq = 0;
      tick(3);
      chk(w >= RF ? "R5 cleared" : "R4 ignored", lineDriveLow, w < RF);
      chk(w >= RF ? "R5 shutdown" : "R4 shutdown", shutdownReq, w < RF);
      if (w < RF) clearLatch();
    end

    // R5 exact release cycle
    setLatch();
    resetReq = 1;
    tick(RF);
    chk("R5 before edge", lineDriveLow, 1'b1);
    tick();
    chk("R5 at edge", lineDriveLow, 1'b0);
    resetReq = 0; tick(2);

    // R6 trip priority over held reset
    ocFlag = 1; lowCmd = 1; resetReq = 1;
    tick(RF + 4);
    chk("R6 held", lineDriveLow, 1'b1);
    ocFlag = 0;
    tick();
    chk("R6 released", lineDriveLow, 1'b0);
    lowCmd = 0; resetReq = 0; tick(2);

    // R7/R8/R9 external line pulse sweep
    for (int w = 1; w <= LF + 2; w++) begin
      lineSense = 0;
      tick(w);
      chk(w >= LF ? "R7 shutdown" : "R8 shutdown", shutdownReq, w >= LF);
      chk("R7 no local drive", lineDriveLow, 1'b0);
      lineSense = 1;
      tick();
      chk("R9 release", shutdownReq, 1'b0);
      tick(2);
    end

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nChk++; nBad++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule